// File: doc/BRIEF.md
# Cascaded Interrupt Request Aggregator

This block collects single-cycle event pulses from several neighbouring units and reduces them to one level-type interrupt request for an external processor. Events are held in latching pending bits at the lowest tier. Software clears each of them by writing a one to it. Masks and enables decide which pending bits reach the tier above. The tiers above are read-only summaries, computed from the masked tier below. The last gate is a single output-enable bit.

There are three routes to the top-level status word:
- **Switch route (three tiers).** Leaf pending/mask pairs exist for the buffer manager, the switch engine and three port MACs. Each leaf gives one bit of a switch-summary word. That word has its own mask and drives one top-level bit.
- **Timestamp route (two tiers).** A timestamp status word with its own enable word drives one top-level bit directly.
- **Link-layer PHY route.** Two PHY event inputs latch straight into top-level bits.

Software uses a plain synchronous register port. A write takes effect on the clock edge at which `reg_we_i` is high. Read data is a combinational function of `reg_addr_i`. There is no data stream here, so no pin carries a valid/ready handshake: all pins are plain control and status, and no input can stall the block.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset every pending bit, mask, enable and the output-enable bit read as zero, and `irq_o` is low.
- R2: A pulse on an event input sets its latching bit on that clock edge, whether or not the bit is masked. The latching bits and their addresses are:
  - buffer-manager leaf (addr 7): bit0 = status A, bit1 = status B;
  - switch-engine leaf (addr 9): bit0;
  - timestamp status (addr 3): bit 2p = transmit capture of port p, bit 2p+1 = receive capture of port p, bits 6..7 = GPIO captures 0..1, bit 8 = timer.
- R3: Writing to a latching register clears exactly the bits written as one and leaves the others unchanged. If an event pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R4: The switch-summary word (addr 5, read-only) has these bits, each the OR of that leaf's pending bits ANDed with its leaf mask:
  - bit0: buffer manager (mask at addr 8);
  - bit1: switch engine (mask at addr 10);
  - bits 2..4: MAC ports 0..2.
  Writes to addr 5 have no effect.
- R5: Top-level status (addr 0) has two read-only summary bits:
  - bit 28 is the OR of the switch-summary bits ANDed with the switch-summary mask (addr 6, bits 4:0);
  - bit 29 is the OR of the timestamp status ANDed with the timestamp enable (addr 4, bits 8:0).
  Writing ones to bits 28 or 29 has no effect. Because the summaries are recomputed every cycle, clearing a leaf clears the summary bits above it.
- R6: PHY A and PHY B pulses latch into top-level status bits 26 and 27. These bits are cleared by writing one to them at addr 0.
- R7: For port p, the MAC pending register at addr 11+2p always reads zero. The MAC mask at addr 12+2p stores and reads back bits 3:0.
- R8: `irq_o` is registered. It is high in the cycle after an edge at which the output enable (addr 2, bit0) was one and at least one top-level status bit was set together with its top-level enable bit. The top-level enable bits are at addr 1: bit 26 PHY A, bit 27 PHY B, bit 28 switch, bit 29 timestamp. The output stays high while that condition holds.
- R9: The enable and mask registers at addr 1, 2, 4, 6, 8 and 10 store the bits named above, and read back zero in all other bit positions. Unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| bm_evt_i | input | 2 | Buffer-manager event pulses (bit0 status A, bit1 status B) |
| se_evt_i | input | 1 | Switch-engine event pulse |
| ts_evt_i | input | 9 | Timestamp event pulses, same layout as the timestamp status |
| phy_a_evt_i | input | 1 | PHY A event pulse |
| phy_b_evt_i | input | 1 | PHY B event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong latch or clear decision in a leaf shows up at once on the read port, in the same cycle that its address is presented. The same fault shows up one edge later on `irq_o` when the whole enable path for it is open. A fault in a summary tier or in an enable is invisible on its own leaf, but it is visible in the summary word above it and in the cycle-after behaviour of `irq_o`. For that reason, every check compares the read data and the interrupt level together, against a model that is stepped on every edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW       = 32;
  localparam int AW       = 5;
  localparam int N_PORTS  = 3;
  localparam int BM_W     = 2;
  localparam int SE_W     = 1;
  localparam int SW_W     = 2 + N_PORTS;

  // register word addresses
  localparam logic [AW-1:0] A_TOP_STAT = 5'd0;
  localparam logic [AW-1:0] A_TOP_EN   = 5'd1;
  localparam logic [AW-1:0] A_OUT_CFG  = 5'd2;
  localparam logic [AW-1:0] A_TS_STAT  = 5'd3;
  localparam logic [AW-1:0] A_TS_EN    = 5'd4;
  localparam logic [AW-1:0] A_SW_PEND  = 5'd5;
  localparam logic [AW-1:0] A_SW_MASK  = 5'd6;
  localparam logic [AW-1:0] A_BM_PEND  = 5'd7;
  localparam logic [AW-1:0] A_BM_MASK  = 5'd8;
  localparam logic [AW-1:0] A_SE_PEND  = 5'd9;
  localparam logic [AW-1:0] A_SE_MASK  = 5'd10;
  localparam int            MAC_BASE   = 11;

  // top-level bit positions (bit 29 is the timestamp enable position)
  localparam int BIT_PHY_A = 26;
  localparam int BIT_PHY_B = 27;
  localparam int BIT_SW    = 28;
  localparam int BIT_TS    = 29;
  localparam int TOP_LO    = BIT_PHY_A;
  localparam int TOP_N     = 4;

  // switch-summary bit positions
  localparam int SWB_BM   = 0;
  localparam int SWB_SE   = 1;
  localparam int SWB_MAC0 = 2;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  AST_LATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i))) else $error("latch"); // R2
  AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((pend_o & $past(clr_i & ~set_i)) == '0)) else $error("clear"); // R3
endmodule

// File: rtl/irq_rw_reg.sv
module irq_rw_reg #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         out_en_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic any_live;
  logic irq_q;

  assign any_live = |(src_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= out_en_i & any_live;
  end

  assign irq_o = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> !irq_o) else $error("gate"); // R8
  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_i && (|(src_i & en_i))) |=> irq_o) else $error("level"); // R8
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top import irq_agg_pkg::*; #(
  parameter int NGPIO      = 2,
  parameter int MAC_MASK_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [4:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic [1:0]      bm_evt_i,
  input  logic            se_evt_i,
  input  logic [6+NGPIO:0] ts_evt_i,
  input  logic            phy_a_evt_i,
  input  logic            phy_b_evt_i,
  output logic            irq_o
);
  localparam int TS_W = 7 + NGPIO;

  function automatic logic wr_hit(input logic [AW-1:0] a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  // ---------------- leaf tier: buffer manager / switch engine ----------------
  logic [BM_W-1:0] bm_pend, bm_mask;
  logic [SE_W-1:0] se_pend, se_mask;

  irq_w1c_bank #(.W(BM_W)) u_bm_pend (
    .clk_i, .rst_ni, .set_i(bm_evt_i),
    .clr_i(wr_hit(A_BM_PEND) ? reg_wdata_i[BM_W-1:0] : '0),
    .pend_o(bm_pend));
  irq_rw_reg #(.W(BM_W)) u_bm_mask (
    .clk_i, .rst_ni, .we_i(wr_hit(A_BM_MASK)),
    .d_i(reg_wdata_i[BM_W-1:0]), .q_o(bm_mask));

  irq_w1c_bank #(.W(SE_W)) u_se_pend (
    .clk_i, .rst_ni, .set_i(se_evt_i),
    .clr_i(wr_hit(A_SE_PEND) ? reg_wdata_i[SE_W-1:0] : '0),
    .pend_o(se_pend));
  irq_rw_reg #(.W(SE_W)) u_se_mask (
    .clk_i, .rst_ni, .we_i(wr_hit(A_SE_MASK)),
    .d_i(reg_wdata_i[SE_W-1:0]), .q_o(se_mask));

  // ---------------- leaf tier: port MACs (no live sources) ----------------
  logic [MAC_MASK_W-1:0] mac_mask [N_PORTS];
  logic [MAC_MASK_W-1:0] mac_pend [N_PORTS];
  logic [N_PORTS-1:0]    mac_sum;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_mac
    assign mac_pend[p] = '0;
    irq_rw_reg #(.W(MAC_MASK_W)) u_mac_mask (
      .clk_i, .rst_ni,
      .we_i(wr_hit(AW'(MAC_BASE + 2*p + 1))),
      .d_i(reg_wdata_i[MAC_MASK_W-1:0]), .q_o(mac_mask[p]));
    assign mac_sum[p] = |(mac_pend[p] & mac_mask[p]);
  end

  // ---------------- switch-summary tier ----------------
  logic [SW_W-1:0] sw_pend, sw_mask;

  always_comb begin
    sw_pend = '0;
    sw_pend[SWB_BM] = |(bm_pend & bm_mask);
    sw_pend[SWB_SE] = |(se_pend & se_mask);
    sw_pend[SWB_MAC0 +: N_PORTS] = mac_sum;
  end

  irq_rw_reg #(.W(SW_W)) u_sw_mask (
    .clk_i, .rst_ni, .we_i(wr_hit(A_SW_MASK)),
    .d_i(reg_wdata_i[SW_W-1:0]), .q_o(sw_mask));

  // ---------------- timestamp tier ----------------
  logic [TS_W-1:0] ts_stat, ts_en;

  irq_w1c_bank #(.W(TS_W)) u_ts_stat (
    .clk_i, .rst_ni, .set_i(ts_evt_i),
    .clr_i(wr_hit(A_TS_STAT) ? reg_wdata_i[TS_W-1:0] : '0),
    .pend_o(ts_stat));
  irq_rw_reg #(.W(TS_W)) u_ts_en (
    .clk_i, .rst_ni, .we_i(wr_hit(A_TS_EN)),
    .d_i(reg_wdata_i[TS_W-1:0]), .q_o(ts_en));

  // ---------------- top tier ----------------
  logic [1:0]       phy_pend;
  logic [TOP_N-1:0] top_en;
  logic             out_en;
  logic [DW-1:0]    top_stat, top_en_w;

  irq_w1c_bank #(.W(2)) u_phy_pend (
    .clk_i, .rst_ni, .set_i({phy_b_evt_i, phy_a_evt_i}),
    .clr_i(wr_hit(A_TOP_STAT) ? reg_wdata_i[BIT_PHY_B:BIT_PHY_A] : 2'b00),
    .pend_o(phy_pend));
  irq_rw_reg #(.W(TOP_N)) u_top_en (
    .clk_i, .rst_ni, .we_i(wr_hit(A_TOP_EN)),
    .d_i(reg_wdata_i[TOP_LO +: TOP_N]), .q_o(top_en));
  irq_rw_reg #(.W(1)) u_out_cfg (
    .clk_i, .rst_ni, .we_i(wr_hit(A_OUT_CFG)),
    .d_i(reg_wdata_i[0]), .q_o(out_en));

  always_comb begin
    top_stat = '0;
    top_stat[BIT_PHY_A] = phy_pend[0];
    top_stat[BIT_PHY_B] = phy_pend[1];
    top_stat[BIT_SW]    = |(sw_pend & sw_mask);
    top_stat[BIT_TS]    = |(ts_stat & ts_en);
    top_en_w = '0;
    top_en_w[TOP_LO +: TOP_N] = top_en;
  end

  irq_out_stage #(.W(DW)) u_out (
    .clk_i, .rst_ni, .out_en_i(out_en),
    .src_i(top_stat), .en_i(top_en_w), .irq_o(irq_o));

  // ---------------- read port ----------------
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_TOP_STAT: reg_rdata_o = top_stat;
      A_TOP_EN:   reg_rdata_o = top_en_w;
      A_OUT_CFG:  reg_rdata_o = DW'(out_en);
      A_TS_STAT:  reg_rdata_o = DW'(ts_stat);
      A_TS_EN:    reg_rdata_o = DW'(ts_en);
      A_SW_PEND:  reg_rdata_o = DW'(sw_pend);
      A_SW_MASK:  reg_rdata_o = DW'(sw_mask);
      A_BM_PEND:  reg_rdata_o = DW'(bm_pend);
      A_BM_MASK:  reg_rdata_o = DW'(bm_mask);
      A_SE_PEND:  reg_rdata_o = DW'(se_pend);
      A_SE_MASK:  reg_rdata_o = DW'(se_mask);
      default:    reg_rdata_o = '0;
    endcase
    for (int p = 0; p < N_PORTS; p++) begin
      if (reg_addr_i == AW'(MAC_BASE + 2*p))     reg_rdata_o = DW'(mac_pend[p]);
      if (reg_addr_i == AW'(MAC_BASE + 2*p + 1)) reg_rdata_o = DW'(mac_mask[p]);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[DW-1:BIT_TS+1], reg_wdata_i[TOP_LO-1:TS_W]};

  AST_PHY_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_a_evt_i |=> top_stat[BIT_PHY_A]) else $error("phy"); // R6
endmodule

// File: tb/test_irq_cascade_top.sv
`timescale 1ns/1ps
module test_irq_cascade_top;
  localparam real CLK = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  bm_e = '0;
  logic        se_e = 1'b0;
  logic [8:0]  ts_e = '0;
  logic        pa_e = 1'b0, pb_e = 1'b0;
  logic        irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  irq_cascade_top i_irq_cascade_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bm_evt_i(bm_e), .se_evt_i(se_e),
    .ts_evt_i(ts_e), .phy_a_evt_i(pa_e), .phy_b_evt_i(pb_e), .irq_o(irq));

  // ---------------- model ----------------
  logic [3:0] m_top_en;
  logic       m_out_en, m_irq, m_se, m_se_mask;
  logic [8:0] m_ts, m_ts_en;
  logic [4:0] m_sw_mask;
  logic [1:0] m_bm, m_bm_mask, m_phy;
  logic [3:0] m_mac [3];

  task automatic m_reset();
    m_top_en = 0; m_out_en = 0; m_irq = 0; m_se = 0; m_se_mask = 0;
    m_ts = 0; m_ts_en = 0; m_sw_mask = 0; m_bm = 0; m_bm_mask = 0; m_phy = 0;
    for (int p = 0; p < 3; p++) m_mac[p] = 0;
  endtask

  function automatic logic [4:0] f_sw();
    return {3'b000, m_se & m_se_mask, |(m_bm & m_bm_mask)};
  endfunction

  function automatic logic [31:0] f_top();
    logic [31:0] v = 0;
    v[26] = m_phy[0]; v[27] = m_phy[1];
    v[28] = |(f_sw() & m_sw_mask);
    v[29] = |(m_ts & m_ts_en);
    return v;
  endfunction

  function automatic logic [31:0] f_read(input logic [4:0] a);
    case (a)
      0: return f_top();
      1: return {2'b0, m_top_en, 26'b0};
      2: return {31'b0, m_out_en};
      3: return {23'b0, m_ts};
      4: return {23'b0, m_ts_en};
      5: return {27'b0, f_sw()};
      6: return {27'b0, m_sw_mask};
      7: return {30'b0, m_bm};
      8: return {30'b0, m_bm_mask};
      9: return {31'b0, m_se};
      10: return {31'b0, m_se_mask};
      12: return {28'b0, m_mac[0]};
      14: return {28'b0, m_mac[1]};
      16: return {28'b0, m_mac[2]};
      default: return 0;
    endcase
  endfunction

  function automatic string f_tag(input logic [4:0] a);
    case (a)
      0: return "R5 R6";
      3, 7, 9: return "R2 R3";
      5: return "R4";
      11, 12, 13, 14, 15, 16: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic m_step(input logic w, input logic [4:0] a, input logic [31:0] d,
                        input logic [1:0] b, input logic s, input logic [8:0] t,
                        input logic pa, input logic pb);
    logic irq_n;
    irq_n = m_out_en && |(f_top() & {2'b0, m_top_en, 26'b0});
    m_bm  = (m_bm  & ~((w && a == 7) ? d[1:0] : 2'b0)) | b;
    m_se  = (m_se  & ~((w && a == 9) ? d[0]   : 1'b0)) | s;
    m_ts  = (m_ts  & ~((w && a == 3) ? d[8:0] : 9'b0)) | t;
    m_phy = (m_phy & ~((w && a == 0) ? d[27:26] : 2'b0)) | {pb, pa};
    if (w) begin
      case (a)
        1: m_top_en = d[29:26];
        2: m_out_en = d[0];
        4: m_ts_en = d[8:0];
        6: m_sw_mask = d[4:0];
        8: m_bm_mask = d[1:0];
        10: m_se_mask = d[0];
        12: m_mac[0] = d[3:0];
        14: m_mac[1] = d[3:0];
        16: m_mac[2] = d[3:0];
        default: ;
      endcase
    end
    m_irq = irq_n;
  endtask

  // ---------------- drive / check ----------------
  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d,
                     input logic [1:0] b, input logic s, input logic [8:0] t,
                     input logic pa, input logic pb);
    @(negedge clk);
    we = w; addr = a; wdata = d; bm_e = b; se_e = s; ts_e = t; pa_e = pa; pb_e = pb;
    @(posedge clk);
    m_step(w, a, d, b, s, t, pa, pb);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 2'b0, 1'b0, 9'b0, 1'b0, 1'b0);
  endtask

  task automatic check_reg(input logic [4:0] a, input string tag);
    @(negedge clk);
    we = 0; addr = a; bm_e = 0; se_e = 0; ts_e = 0; pa_e = 0; pb_e = 0;
    #1;
    n_vec++;
    if (rdata !== f_read(a)) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, rdata, f_read(a));
    end
    n_vec++;
    if (irq !== m_irq) begin
      n_bad++;
      $display("FAIL R8 irq: got %b expected %b", irq, m_irq);
    end
    @(posedge clk);
    m_step(1'b0, a, 32'h0, 2'b0, 1'b0, 9'b0, 1'b0, 1'b0);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 18; a++) check_reg(5'(a), tag);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: all zero after reset
    sweep("R1");

    // R2: masked leaf still latches; R3: set wins over clear
    cyc(1'b0, 0, 0, 2'b01, 1'b1, 9'h100, 1'b0, 1'b0);
    check_reg(7, "R2"); check_reg(9, "R2"); check_reg(3, "R2");
    cyc(1'b1, 7, 32'h3, 2'b01, 1'b0, 9'b0, 1'b0, 1'b0);
    check_reg(7, "R3 set-wins");
    wr(7, 32'h2);
    check_reg(7, "R3 zero-bit untouched");
    // R4: summary is read-only and follows masked leaf
    wr(5, 32'h1f);
    check_reg(5, "R4 write ignored");
    wr(8, 32'h1);
    check_reg(5, "R4");
    // R5: chain to top bit 28 and bit 29, writes of ones ignored
    wr(6, 32'h01); wr(4, 32'h100);
    wr(0, 32'h3000_0000);
    check_reg(0, "R5");
    // R8: open enables, irq follows one cycle later
    wr(1, 32'h3c00_0000);
    check_reg(0, "R8");
    wr(2, 32'h1);
    check_reg(0, "R8 out-en");
    check_reg(0, "R8 level");
    // R5: clearing the leaf drops the summaries and irq
    wr(7, 32'h1); wr(3, 32'h1ff); wr(9, 32'h1);
    check_reg(0, "R5 leaf clear");
    check_reg(0, "R8 drop");
    // R6: PHY bits latch and clear at top
    cyc(1'b0, 0, 0, 2'b0, 1'b0, 9'b0, 1'b1, 1'b1);
    check_reg(0, "R6");
    wr(0, 32'h0400_0000);
    check_reg(0, "R6 clear A");
    // R7: MAC pending reads zero, masks writable
    wr(12, 32'hffff_fffa); wr(14, 32'h5); wr(16, 32'h9); wr(11, 32'hf);
    sweep("R7 R9");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      a = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 17);
      d = ($urandom % 3 == 0) ? 32'hffff_ffff : $urandom;
      cyc(($urandom % 3) == 0, a, d,
          2'(($urandom % 4 == 0) ? $urandom : 0), ($urandom % 6) == 0,
          9'(($urandom % 4 == 0) ? ($urandom & $urandom) : 0),
          ($urandom % 8) == 0, ($urandom % 8) == 0);
      if (i % 4 == 0) check_reg(5'($urandom % 17), f_tag(5'($urandom % 17)));
      if (i % 150 == 149) sweep("R2 R3 R4 R5 R9");
    end
    for (int a = 0; a < 17; a++) check_reg(5'(a), f_tag(5'(a)));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule